// File: doc/BRIEF.md
# Receive Frame Size Checker and Statistics

This block sits at the end of a receive path and sees one pulse per arriving frame, together with the frame's length (CRC excluded) and two control bits: one that raises the length limit for jumbo frames and one that asks the block to keep bad frames. It decides whether the frame is too long. It then updates a bank of statistics counters. None of the counters wraps.

An oversized frame only bumps the oversize counter. Any other frame is counted in a length histogram, in the packet totals and in the octet totals. The histogram and the octet totals both include the 4-byte CRC. Software reads the counters through a registered read port. The octet counters are twice the word width. Reading the low word captures the high word, so a later read of the high word gives a value that matches the low word already read.

Top module: `rx_frame_stats`

## Requirements
- R1: With `long_en` low and `keep_bad` low, a frame whose `frm_len` exceeds 1522 is oversized, and a frame of 1522 or less is not.
- R2: With `long_en` high and `keep_bad` low, the limit is 16384: 16385 is oversized and 16384 is not.
- R3: With `keep_bad` high, no frame is oversized, whatever its length.
- R4: An oversized frame increments the oversize counter (address 12). It leaves every histogram, packet and octet counter unchanged.
- R5: An accepted frame increments exactly one histogram counter, chosen by L = `frm_len` + 4. Address 0 counts L = 64, address 1 counts 65–127, address 2 counts 128–255, address 3 counts 256–511, address 4 counts 512–1023 and address 5 counts L > 1023.
- R6: An accepted frame with L < 64 increments no histogram counter.
- R7: Every accepted frame increments the total-packet counter (address 6). The good-packet counter (address 7) then equals the total-packet counter.
- R8: The total-octet counter (low word at address 8, high word at 9) grows by `frm_len` + 4 for each accepted frame. The good-octet counter (low 10, high 11) holds the same value.
- R9: Every counter holds at its all-ones value instead of wrapping. This includes an octet counter whose addition would pass all-ones.
- R10: A read with `rd_en` high returns the addressed counter on `rd_data` one clock later. Unused addresses return zero, and every counter reads zero after reset.
- R11: A read of address 8 (or 10) captures the matching high word. A later read of address 9 (or 11) returns that captured value, even if frames have arrived in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle pulse per received frame |
| frm_len | input | LEN_W | Frame length in bytes without CRC |
| long_en | input | 1 | Selects the long-frame size limit |
| keep_bad | input | 1 | Disables the oversize decision |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register address |
| rd_data | output | W | Registered read data |

## Verification
The assertions take for granted that `frm_len`, `long_en` and `keep_bad` are defined whenever `frm_valid` is high. They also assume `frm_valid` is a pulse, so each frame is counted once. The bench always drives these three inputs to known values and holds them for exactly one cycle around each pulse. It never lets a read overlap a frame, so every read reports the counters after the previous frame has been counted. The bench uses a narrow word width so that saturation is reached within a short sweep. It sweeps the lengths across every size limit and histogram edge under all four control settings.

// File: rtl/rx_frame_stats.sv
module rx_frame_stats #(
  parameter int W        = 32,
  parameter int LEN_W    = 16,
  parameter int STD_MAX  = 1522,
  parameter int LONG_MAX = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             long_en,
  input  logic             keep_bad,
  input  logic             rd_en,
  input  logic [3:0]       rd_addr,
  output logic [W-1:0]     rd_data
);
  localparam int OW = 2 * W;
  localparam int SW = ((OW > LEN_W) ? OW : LEN_W) + 1;

  logic [5:0][W-1:0] bkt;
  logic [W-1:0]      tot_pkts, good_pkts, ovr_cnt;
  logic [OW-1:0]     tot_oct, good_oct;
  logic [W-1:0]      tot_hi_sh, good_hi_sh;

  logic [LEN_W:0] flen;
  logic           over, bhit;
  logic [2:0]     bsel;
  logic [SW-1:0]  oct_sum;
  logic [OW-1:0]  oct_next;

  function automatic logic [W-1:0] sinc(input logic [W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  assign flen = {1'b0, frm_len} + (LEN_W+1)'(4);
  assign over = !keep_bad && ((32'(frm_len) > 32'(LONG_MAX)) ||
                              (!long_en && (32'(frm_len) > 32'(STD_MAX))));

  always_comb begin
    bhit = 1'b1;
    bsel = 3'd0;
    if      (32'(flen) > 32'd1023) bsel = 3'd5;
    else if (32'(flen) > 32'd511)  bsel = 3'd4;
    else if (32'(flen) > 32'd255)  bsel = 3'd3;
    else if (32'(flen) > 32'd127)  bsel = 3'd2;
    else if (32'(flen) > 32'd64)   bsel = 3'd1;
    else if (32'(flen) == 32'd64)  bsel = 3'd0;
    else                           bhit = 1'b0;
  end

  assign oct_sum  = SW'(tot_oct) + SW'(flen);
  assign oct_next = (oct_sum > SW'({OW{1'b1}})) ? {OW{1'b1}} : oct_sum[OW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bkt       <= '0;
      tot_pkts  <= '0;
      good_pkts <= '0;
      ovr_cnt   <= '0;
      tot_oct   <= '0;
      good_oct  <= '0;
    end else if (frm_valid) begin
      if (over) begin
        ovr_cnt <= sinc(ovr_cnt);
      end else begin
        if (bhit) bkt[bsel] <= sinc(bkt[bsel]);
        tot_pkts  <= sinc(tot_pkts);
        good_pkts <= sinc(tot_pkts);
        tot_oct   <= oct_next;
        good_oct  <= oct_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data    <= '0;
      tot_hi_sh  <= '0;
      good_hi_sh <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: rd_data <= bkt[rd_addr[2:0]];
        4'd6:  rd_data <= tot_pkts;
        4'd7:  rd_data <= good_pkts;
        4'd8:  begin rd_data <= tot_oct[W-1:0];  tot_hi_sh  <= tot_oct[OW-1:W];  end
        4'd9:  rd_data <= tot_hi_sh;
        4'd10: begin rd_data <= good_oct[W-1:0]; good_hi_sh <= good_oct[OW-1:W]; end
        4'd11: rd_data <= good_hi_sh;
        4'd12: rd_data <= ovr_cnt;
        default: rd_data <= '0;
      endcase
    end
  end

  assert_oversize_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && over |=> $stable(tot_pkts) && $stable(tot_oct) && $stable(bkt));

  assert_good_follows_total_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !over |=> good_pkts == tot_pkts);

  assert_good_oct_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !over |=> good_oct == tot_oct);

  assert_short_no_bucket_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && (32'(frm_len) < 32'd60) |=> $stable(bkt));

  assert_keep_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && keep_bad |=> $stable(ovr_cnt));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (&tot_pkts) |=> (&tot_pkts));

  assert_oct_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid || over || (tot_oct != {OW{1'b1}}) |=> tot_oct >= $past(tot_oct));
endmodule

// File: tb/tb_rx_frame_stats.sv
module tb_rx_frame_stats;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int CMAX = 255;
  localparam longint OMAX = 65535;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic [15:0] frm_len = '0;
  logic        long_en = 1'b0;
  logic        keep_bad = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;

  int     m_bkt [6];
  int     m_tot, m_ovr;
  longint m_oct;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_stats #(.W(W), .LEN_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_len(frm_len),
    .long_en(long_en), .keep_bad(keep_bad), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    foreach (m_bkt[i]) m_bkt[i] = 0;
    m_tot = 0; m_ovr = 0; m_oct = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 4'(a);
    @(negedge clk);
    v = int'(rd_data);
    rd_en = 1'b0;
  endtask

  task automatic frame(input int len, input bit le, input bit kb);
    int fl;
    bit ov;
    ov = !kb && (len > 16384 || (!le && len > 1522));
    if (ov) begin
      if (m_ovr < CMAX) m_ovr++;
    end else begin
      fl = len + 4;
      if      (fl > 1023) begin if (m_bkt[5] < CMAX) m_bkt[5]++; end
      else if (fl > 511)  begin if (m_bkt[4] < CMAX) m_bkt[4]++; end
      else if (fl > 255)  begin if (m_bkt[3] < CMAX) m_bkt[3]++; end
      else if (fl > 127)  begin if (m_bkt[2] < CMAX) m_bkt[2]++; end
      else if (fl > 64)   begin if (m_bkt[1] < CMAX) m_bkt[1]++; end
      else if (fl == 64)  begin if (m_bkt[0] < CMAX) m_bkt[0]++; end
      if (m_tot < CMAX) m_tot++;
      m_oct = m_oct + fl;
      if (m_oct > OMAX) m_oct = OMAX;
    end
    @(negedge clk);
    frm_valid = 1'b1; frm_len = 16'(len); long_en = le; keep_bad = kb;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic check_all();
    int v;
    for (int i = 0; i < 6; i++) begin
      rd(i, v); check("R5 R6 R9 bucket", v, m_bkt[i]);
    end
    rd(6, v);  check("R7 R9 total packets", v, m_tot);
    rd(7, v);  check("R7 good packets", v, m_tot);
    rd(8, v);  check("R8 R9 octets low", v, int'(m_oct & 255));
    rd(9, v);  check("R8 R11 octets high", v, int'(m_oct >> 8));
    rd(10, v); check("R8 good octets low", v, int'(m_oct & 255));
    rd(11, v); check("R8 R11 good octets high", v, int'(m_oct >> 8));
    rd(12, v); check("R1 R2 R3 R4 oversize", v, m_ovr);
  endtask

  function automatic bit edge_len(input int n);
    int e [] = '{59, 60, 61, 62, 123, 124, 125, 251, 252, 253, 507, 508, 509,
                 1019, 1020, 1021, 1521, 1522, 1523, 16383, 16384, 16385};
    foreach (e[i]) if (e[i] == n) return 1'b1;
    return (n % 64) == 0;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    do_reset();
    check_all();                          // R10 reset state
    rd(13, v); check("R10 unused address", v, 0);
    rd(15, v); check("R10 unused address", v, 0);

    // R11 latch: 304 octets (hi 1), then +1004 -> 1308 (hi 5)
    frame(300, 1'b0, 1'b0);
    rd(8, v);  check("R11 low word", v, 48);
    frame(1000, 1'b0, 1'b0);
    rd(9, v);  check("R11 latched high", v, 1);
    rd(8, v);  check("R11 new low", v, 28);
    rd(9, v);  check("R11 new high", v, 5);
    rd(11, v); check("R11 good high unlatched", v, 0);
    rd(10, v); rd(11, v); check("R11 good high", v, 5);

    for (int c = 0; c < 4; c++) begin
      do_reset();
      for (int n = 0; n <= 1600; n++) begin
        frame(n, c[0], c[1]);
        if (edge_len(n)) check_all();
      end
      for (int n = 16376; n <= 16394; n++) begin
        frame(n, c[0], c[1]);
        if (edge_len(n)) check_all();
      end
      check_all();
    end

    do_reset();
    frame(1523, 1'b0, 1'b0);
    rd(12, v); check("R1 oversize count", v, 1);
    rd(6, v);  check("R4 total unchanged", v, 0);
    frame(16385, 1'b1, 1'b0);
    rd(12, v); check("R2 oversize count", v, 2);
    frame(20000, 1'b0, 1'b1);
    rd(5, v);  check("R3 kept frame bucket", v, 1);
    rd(12, v); check("R3 oversize unchanged", v, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule